// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps one processor's reservation for atomic read-modify-write sequences. A load-linked operation records the word address it read and marks the reservation live. A later store-conditional to that word may write memory only while the reservation is still live. The block gates the memory write-enable of the conditional store and produces the 1-bit success value that the pipeline writes back to the destination register.

The reservation is lost when another agent writes the reserved word, when an exception or interrupt is taken, or when any store-conditional is executed. All addresses on the ports are word addresses, so two byte addresses in the same word match. The store data travels straight to memory and does not pass through this block. Only the write strobe is gated here.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no reservation exists, so a store-conditional issued before any load-linked fails with `mem_we` = 0 and `sc_result` = 0.
- R2: A load-linked records its word address. A later store-conditional to the same word, with nothing in between that breaks the reservation, succeeds with `mem_we` = 1 and `sc_result` = 1.
- R3: `mem_we` and `sc_result` are combinational outputs, valid in the same cycle as `sc_valid`. Both are 0 in every cycle where `sc_valid` is 0.
- R4: A store-conditional whose word address differs from the reserved address fails.
- R5: Every store-conditional drops the reservation, whether it succeeds or fails. A second store-conditional with no new load-linked in between fails.
- R6: A snooped foreign write (`snoop_valid` = 1) to the reserved word drops the reservation from the next cycle on. A snooped write to any other word has no effect.
- R7: A snooped foreign write to the reserved word in the same cycle as a store-conditional makes that store-conditional fail.
- R8: An exception pulse (`exc_pulse` = 1) drops the reservation. A store-conditional issued in the same cycle as an exception pulse fails.
- R9: A new load-linked replaces any existing reservation. After it, only the new address can succeed.
- R10: Same-cycle priority for the next reservation is, from highest to lowest: exception (drop), load-linked (set to the new address), store-conditional (drop), matching snoop (drop). A store-conditional issued together with a load-linked is judged against the previous reservation.
- R11: A load-linked in the same cycle as a snoop to the same word still leaves a live reservation on that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_valid | input | 1 | Load-linked issued this cycle |
| ll_addr | input | AW | Word address of the load-linked |
| sc_valid | input | 1 | Store-conditional issued this cycle |
| sc_addr | input | AW | Word address of the store-conditional |
| snoop_valid | input | 1 | Another agent writes memory this cycle |
| snoop_addr | input | AW | Word address of the foreign write |
| exc_pulse | input | 1 | Exception or interrupt taken this cycle |
| mem_we | output | 1 | Gated memory write-enable for the store-conditional |
| sc_result | output | 1 | Success value written back to the destination register |

## Verification
The assertions assume that every input is a known 0 or 1 on each rising edge and that the pulses last exactly one cycle. They do not assume that load-linked, store-conditional, snoop and exception are mutually exclusive. The properties are written for any overlap of the four, because the same-cycle priorities are part of the required behaviour. The stimulus drives every input on the falling edge, so it is stable at the rising edge. Directed sequences cover each same-cycle collision. A pseudorandom phase then draws addresses from four words, so that matches and mismatches both occur often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    // Outcome of judging a store-conditional against the reservation.
    typedef enum logic [2:0] {
        SCV_IDLE      = 3'd0,
        SCV_PASS      = 3'd1,
        SCV_NO_LINK   = 3'd2,
        SCV_ADDR_MISS = 3'd3,
        SCV_SNOOPED   = 3'd4,
        SCV_TRAPPED   = 3'd5
    } sc_verdict_e;

    // Source that decides the next reservation state, highest first.
    typedef enum logic [2:0] {
        RSV_HOLD  = 3'd0,
        RSV_TRAP  = 3'd1,
        RSV_LOAD  = 3'd2,
        RSV_STORE = 3'd3,
        RSV_SNOOP = 3'd4
    } rsv_cause_e;

endpackage

// File: rtl/llsc_word_cmp.sv
module llsc_word_cmp #(
    parameter int AW = 30
) (
    input  logic          qual,
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic          hit
);
    // Word-address equality, qualified by a valid term.
    always_comb begin
        hit = qual && (a == b);
    end
endmodule

// File: rtl/llsc_rsv_reg.sv
module llsc_rsv_reg
    import llsc_pkg::*;
#(
    parameter int AW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_pulse,
    input  logic          ll_valid,
    input  logic [AW-1:0] ll_addr,
    input  logic          sc_valid,
    input  logic          snoop_hit,
    output logic          rsv_valid_q,
    output logic [AW-1:0] rsv_addr_q
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } rsv_t;

    rsv_t       st_d;
    rsv_t       st_q;
    rsv_cause_e cause;

    // Priority of the sources that change the reservation.
    always_comb begin
        if (exc_pulse)      cause = RSV_TRAP;
        else if (ll_valid)  cause = RSV_LOAD;
        else if (sc_valid)  cause = RSV_STORE;
        else if (snoop_hit) cause = RSV_SNOOP;
        else                cause = RSV_HOLD;
    end

    always_comb begin
        st_d = st_q;
        unique case (cause)
            RSV_TRAP:  st_d.valid = 1'b0;
            RSV_LOAD: begin
                st_d.valid = 1'b1;
                st_d.addr  = ll_addr;
            end
            RSV_STORE: st_d.valid = 1'b0;
            RSV_SNOOP: st_d.valid = 1'b0;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsv_valid_q = st_q.valid;
    assign rsv_addr_q  = st_q.addr;
endmodule

// File: rtl/llsc_sc_judge.sv
module llsc_sc_judge
    import llsc_pkg::*;
(
    input  logic        sc_valid,
    input  logic        rsv_valid,
    input  logic        addr_match,
    input  logic        snoop_hit,
    input  logic        exc_pulse,
    output sc_verdict_e verdict
);
    // Every failure reason takes precedence over a pass.
    always_comb begin
        if (!sc_valid)        verdict = SCV_IDLE;
        else if (exc_pulse)   verdict = SCV_TRAPPED;
        else if (!rsv_valid)  verdict = SCV_NO_LINK;
        else if (!addr_match) verdict = SCV_ADDR_MISS;
        else if (snoop_hit)   verdict = SCV_SNOOPED;
        else                  verdict = SCV_PASS;
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int AW = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ll_valid,
    input  logic [AW-1:0] ll_addr,
    input  logic          sc_valid,
    input  logic [AW-1:0] sc_addr,
    input  logic          snoop_valid,
    input  logic [AW-1:0] snoop_addr,
    input  logic          exc_pulse,
    output logic          mem_we,
    output logic          sc_result
);
    logic          rsv_valid_q;
    logic [AW-1:0] rsv_addr_q;
    logic          snoop_hit;
    logic          sc_match;
    sc_verdict_e   verdict;

    llsc_word_cmp #(.AW(AW)) u_snoop_cmp (
        .qual (snoop_valid && rsv_valid_q),
        .a    (snoop_addr),
        .b    (rsv_addr_q),
        .hit  (snoop_hit)
    );

    llsc_word_cmp #(.AW(AW)) u_sc_cmp (
        .qual (1'b1),
        .a    (sc_addr),
        .b    (rsv_addr_q),
        .hit  (sc_match)
    );

    llsc_rsv_reg #(.AW(AW)) u_rsv (
        .clk         (clk),
        .rst_n       (rst_n),
        .exc_pulse   (exc_pulse),
        .ll_valid    (ll_valid),
        .ll_addr     (ll_addr),
        .sc_valid    (sc_valid),
        .snoop_hit   (snoop_hit),
        .rsv_valid_q (rsv_valid_q),
        .rsv_addr_q  (rsv_addr_q)
    );

    llsc_sc_judge u_judge (
        .sc_valid   (sc_valid),
        .rsv_valid  (rsv_valid_q),
        .addr_match (sc_match),
        .snoop_hit  (snoop_hit),
        .exc_pulse  (exc_pulse),
        .verdict    (verdict)
    );

    assign mem_we    = (verdict == SCV_PASS);
    assign sc_result = (verdict == SCV_PASS);
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int AW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ll_valid,
    input logic [AW-1:0] ll_addr,
    input logic          sc_valid,
    input logic [AW-1:0] sc_addr,
    input logic          snoop_valid,
    input logic [AW-1:0] snoop_addr,
    input logic          exc_pulse,
    input logic          mem_we,
    input logic          sc_result,
    input logic          rsv_valid,
    input logic [AW-1:0] rsv_addr
);
    // R3
    idle_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_valid |-> (!mem_we && !sc_result));

    // R2
    pass_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_result |-> (rsv_valid && sc_addr == rsv_addr));

    // R4
    addr_miss_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && sc_addr != rsv_addr) |-> !mem_we);

    // R5
    sc_drops_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && !ll_valid) |=> !rsv_valid);

    // R6
    snoop_drops_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && rsv_valid && snoop_addr == rsv_addr && !ll_valid) |=> !rsv_valid);

    // R7
    snoop_same_cycle_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_valid && snoop_valid && snoop_addr == sc_addr) |-> !sc_result);

    // R8
    exc_drops_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |=> !rsv_valid);

    // R8
    exc_same_cycle_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |-> !mem_we);

    // R9
    ll_sets_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ll_valid && !exc_pulse) |=> (rsv_valid && rsv_addr == $past(ll_addr)));
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW)) u_llsc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ll_valid    (ll_valid),
    .ll_addr     (ll_addr),
    .sc_valid    (sc_valid),
    .sc_addr     (sc_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .exc_pulse   (exc_pulse),
    .mem_we      (mem_we),
    .sc_result   (sc_result),
    .rsv_valid   (rsv_valid_q),
    .rsv_addr    (rsv_addr_q)
);

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
    localparam int AW = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ll_valid = 1'b0;
    logic [AW-1:0] ll_addr = '0;
    logic          sc_valid = 1'b0;
    logic [AW-1:0] sc_addr = '0;
    logic          snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic          exc_pulse = 1'b0;
    logic          mem_we;
    logic          sc_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference reservation.
    bit      ref_live = 0;
    longint  ref_word = 0;

    always #2 clk = ~clk;

    llsc_monitor #(.AW(AW)) dut (
        .clk, .rst_n, .ll_valid, .ll_addr, .sc_valid, .sc_addr,
        .snoop_valid, .snoop_addr, .exc_pulse, .mem_we, .sc_result
    );

    task automatic check1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive after falling edge, check, then advance the model at the rising edge.
    task automatic cyc(string tag, logic ll, int lla, logic sc, int sca,
                       logic sn, int sna, logic ex);
        bit exp_ok;
        ll_valid    = ll;  ll_addr    = AW'(lla);
        sc_valid    = sc;  sc_addr    = AW'(sca);
        snoop_valid = sn;  snoop_addr = AW'(sna);
        exc_pulse   = ex;
        #1;
        exp_ok = sc && ref_live && (longint'(sca) == ref_word)
                 && !(sn && longint'(sna) == ref_word) && !ex;
        check1(tag, "mem_we", mem_we, exp_ok);
        check1(tag, "sc_result", sc_result, exp_ok);
        @(posedge clk);
        if (ex) ref_live = 0;
        else if (ll) begin ref_live = 1; ref_word = lla; end
        else if (sc) ref_live = 0;
        else if (sn && ref_live && longint'(sna) == ref_word) ref_live = 0;
        @(negedge clk);
    endtask

    task automatic idle(string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, then a store-conditional with no reservation
        idle("R1");
        cyc("R1", 0, 0, 1, 0, 0, 0, 0);
        cyc("R1", 0, 0, 1, 5, 0, 0, 0);
        // R2: plain pair
        cyc("R2", 1, 'h10, 0, 0, 0, 0, 0);
        idle("R2");
        cyc("R2", 0, 0, 1, 'h10, 0, 0, 0);
        // R4: address mismatch
        cyc("R4", 1, 'h20, 0, 0, 0, 0, 0);
        cyc("R4", 0, 0, 1, 'h21, 0, 0, 0);
        // R5: second conditional store fails, also after a failed one
        cyc("R5", 1, 'h30, 0, 0, 0, 0, 0);
        cyc("R5", 0, 0, 1, 'h30, 0, 0, 0);
        cyc("R5", 0, 0, 1, 'h30, 0, 0, 0);
        cyc("R5", 1, 'h31, 0, 0, 0, 0, 0);
        cyc("R5", 0, 0, 1, 'h32, 0, 0, 0);
        cyc("R5", 0, 0, 1, 'h31, 0, 0, 0);
        // R6: snoop to another word is harmless, to the reserved word breaks
        cyc("R6", 1, 'h40, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 1, 'h41, 0);
        cyc("R6", 0, 0, 1, 'h40, 0, 0, 0);
        cyc("R6", 1, 'h40, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 1, 'h40, 0);
        cyc("R6", 0, 0, 1, 'h40, 0, 0, 0);
        // R7: snoop in the same cycle as the conditional store
        cyc("R7", 1, 'h50, 0, 0, 0, 0, 0);
        cyc("R7", 0, 0, 1, 'h50, 1, 'h50, 0);
        cyc("R7", 1, 'h50, 0, 0, 0, 0, 0);
        cyc("R7", 0, 0, 1, 'h50, 1, 'h51, 0);
        // R8: exception before and during the conditional store
        cyc("R8", 1, 'h60, 0, 0, 0, 0, 0);
        cyc("R8", 0, 0, 0, 0, 0, 0, 1);
        cyc("R8", 0, 0, 1, 'h60, 0, 0, 0);
        cyc("R8", 1, 'h60, 0, 0, 0, 0, 0);
        cyc("R8", 0, 0, 1, 'h60, 0, 0, 1);
        // R9: replacement of the reservation
        cyc("R9", 1, 'h70, 0, 0, 0, 0, 0);
        cyc("R9", 1, 'h71, 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 1, 'h70, 0, 0, 0);
        cyc("R9", 1, 'h70, 0, 0, 0, 0, 0);
        cyc("R9", 1, 'h71, 0, 0, 0, 0, 0);
        cyc("R9", 0, 0, 1, 'h71, 0, 0, 0);
        // R10: same-cycle priorities
        cyc("R10", 1, 'h80, 0, 0, 0, 0, 1);
        cyc("R10", 0, 0, 1, 'h80, 0, 0, 0);
        cyc("R10", 1, 'h90, 0, 0, 0, 0, 0);
        cyc("R10", 1, 'h91, 1, 'h90, 0, 0, 0);
        cyc("R10", 0, 0, 1, 'h91, 0, 0, 0);
        // R11: load-linked together with a snoop to the same word
        cyc("R11", 1, 'hA0, 0, 0, 1, 'hA0, 0);
        cyc("R11", 0, 0, 1, 'hA0, 0, 0, 0);
        // R3: pseudorandom mix over four words, outputs compared every cycle
        for (int i = 0; i < 3000; i++) begin
            cyc("R3",
                ($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
                ($urandom_range(0, 2) == 0), int'($urandom_range(0, 3)),
                ($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
                ($urandom_range(0, 15) == 0));
        end
        idle("R3");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule